// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a chain of 4-bit synchronous binary up-counters. Every stage shares one clock. Each stage has a parallel preset, an active-low load, an active-low clear and two count enables. The first enable, `enP`, only permits counting. The second, `enT`, also qualifies the stage's look-ahead carry. Inside the chain, each stage's carry feeds the `enT` of the stage above it, while `enP`, load, clear and the clock are common to all stages. The whole chain therefore behaves as one wide synchronous counter. A single-stage build gives the plain 4-bit counter.

A parameter chooses how the clear acts. In one setting it acts at once, without waiting for a clock edge. In the other it is sampled on the rising clock edge like the other controls. The operations have a fixed priority: clear first, then load, then count, then hold.

Top module: `preset_counter_chain`

## Requirements
- R1: With `ASYNC_CLR=0`, a low `clrN` at a rising edge sets every count bit to 0. Before that edge the count is unchanged.
- R2: With `ASYNC_CLR=1`, a low `clrN` forces the count to 0 at once, with no clock edge needed.
- R3: A low `loadN` at a rising edge copies `preset` into the count. Counting does not happen in that cycle, whatever the enables are.
- R4: Clear takes priority over load. When `clrN` and `loadN` are both low at an edge, the count becomes 0.
- R5: The count rises by one at an edge only when `enP`, `enT` and `loadN` are all high. In every other case it holds its value.
- R6: `carryOut` is high exactly when `enT` is high and every count bit is 1. It does not depend on `enP`, and it follows `enT` with no clock edge.
- R7: The count wraps from all ones to 0. For a single stage this is 15 to 0.
- R8: Bit 0 of `preset` and of `count` is the least significant bit. The highest index is the most significant bit.
- R9: Stage k (k>0) advances only on an edge where all stages below it hold all ones and counting is enabled. The chain steps through all 2^(4·STAGES) values in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clrN | input | 1 | Active-low clear; asynchronous or synchronous according to `ASYNC_CLR` |
| loadN | input | 1 | Active-low parallel load of `preset` |
| enP | input | 1 | Count enable common to all stages |
| enT | input | 1 | Count enable of the lowest stage; also gates the carry |
| preset | input | 4·STAGES | Parallel load value, bit 0 is the LSB |
| count | output | 4·STAGES | Current count, bit 0 is the LSB |
| carryOut | output | 1 | Look-ahead carry of the top stage |

## Verification
The hardest condition to reach from the ports is the upper stage advancing, because that needs every lower nibble at all ones on an enabled edge. A long run from a loaded zero walks the default two-stage chain through all 256 values and its wrap. A reference model in the scoreboard predicts every step of that run. The asynchronous clear is checked on a separate single-stage instance: it is observed in the middle of a cycle, before any edge, while the synchronous instance at the same moment must still show its old value.

// File: rtl/nib_cnt_pkg.sv
package nib_cnt_pkg;
  // Strobes from the control module to the datapath, one per operation.
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/nib_cnt_ctrl.sv
module nib_cnt_ctrl
  import nib_cnt_pkg::*;
(
  input  logic       clrN,
  input  logic       loadN,
  input  logic       enP,
  input  logic       enT,
  output cntStrobe_t strb
);
  // Resolve priority once here: clear, then load, then count.
  always_comb begin
    strb.clr  = ~clrN;
    strb.load = clrN & ~loadN;
    strb.inc  = clrN & loadN & enP & enT;
  end
endmodule

// File: rtl/nib_cnt_dp.sv
module nib_cnt_dp
  import nib_cnt_pkg::*;
#(
  parameter int  W         = 4,
  parameter bit  ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clrN,
  input  cntStrobe_t   strb,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q
);
  logic [W-1:0] qR;
  logic [W-1:0] nxt;

  always_comb begin
    if (strb.load)     nxt = preset;
    else if (strb.inc) nxt = qR + 1'b1;
    else               nxt = qR;
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) qR <= '0;
        else       qR <= nxt;
      end
      // R2: while clear is held low the register reads zero at every edge
      assert_async_clear_R2: assert property (@(posedge clk) !clrN |-> qR == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (strb.clr) qR <= '0;
        else          qR <= nxt;
      end
      // R1: a sampled clear yields zero after the edge
      assert_sync_clear_R1: assert property (@(posedge clk) strb.clr |=> qR == '0);
    end
  endgenerate

  assign q = qR;

  // R3: load captures the preset seen at the edge
  assert_load_R3: assert property (@(posedge clk) disable iff (!clrN)
    strb.load |=> qR == $past(preset));
  // R5/R7: an increment steps by one modulo 2^W
  assert_step_R5: assert property (@(posedge clk) disable iff (!clrN)
    strb.inc |=> qR == W'($past(qR) + 1'b1));
  // R5: no strobe means the value holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!clrN)
    (!strb.load && !strb.inc) |=> $stable(qR));
endmodule

// File: rtl/nib_cnt_stage.sv
module nib_cnt_stage
  import nib_cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clrN,
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q,
  output logic         carry
);
  cntStrobe_t strb;

  nib_cnt_ctrl u_ctrl (
    .clrN  (clrN),
    .loadN (loadN),
    .enP   (enP),
    .enT   (enT),
    .strb  (strb)
  );

  nib_cnt_dp #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_dp (
    .clk    (clk),
    .clrN   (clrN),
    .strb   (strb),
    .preset (preset),
    .q      (q)
  );

  // Look-ahead carry: combinational, gated only by enT
  assign carry = enT & (&q);
endmodule

// File: rtl/preset_counter_chain.sv
module preset_counter_chain #(
  parameter int STAGES    = 2,
  parameter int NIB_W     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic                      clk,
  input  logic                      clrN,
  input  logic                      loadN,
  input  logic                      enP,
  input  logic                      enT,
  input  logic [STAGES*NIB_W-1:0]   preset,
  output logic [STAGES*NIB_W-1:0]   count,
  output logic                      carryOut
);
  localparam int TOT_W = STAGES * NIB_W;

  logic [STAGES:0] tChain;
  assign tChain[0] = enT;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      nib_cnt_stage #(.W(NIB_W), .ASYNC_CLR(ASYNC_CLR)) u_stage (
        .clk    (clk),
        .clrN   (clrN),
        .loadN  (loadN),
        .enP    (enP),
        .enT    (tChain[i]),
        .preset (preset[i*NIB_W +: NIB_W]),
        .q      (count[i*NIB_W +: NIB_W]),
        .carry  (tChain[i+1])
      );
      if (i > 0) begin : g_upper_chk
        // R9: an upper stage stays put unless every lower stage carries
        assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!clrN)
          (loadN && !tChain[i]) |=> $stable(count[i*NIB_W +: NIB_W]));
      end
    end
  endgenerate

  assign carryOut = tChain[STAGES];

  // R7: counting past the carry state wraps the full chain to zero
  assert_chain_wrap_R7: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && enP && carryOut) |=> count == TOT_W'(0));
endmodule

// File: tb/sim_preset_counter_chain.sv
module sim_preset_counter_chain;
  logic       clk = 1'b0;
  logic       clrN = 1'b1, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [7:0] preset = '0;
  logic [7:0] count;
  logic       carryOut;
  logic [3:0] count1;
  logic       carry1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk; // 50 MHz

  // Default build: two stages, synchronous clear
  preset_counter_chain u0 (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .preset(preset), .count(count), .carryOut(carryOut)
  );
  // Single stage, asynchronous clear
  preset_counter_chain #(.STAGES(1), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .preset(preset[3:0]), .count(count1), .carryOut(carry1)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       cy;
    logic [3:0] cnt1;
    logic       cy1;
    string      tag;
  } expItem_t;

  expItem_t   sb[$];
  logic [7:0] mdl = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and queues the predicted result
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [7:0] pv, input string tag);
    expItem_t it;
    @(negedge clk);
    clrN = c; loadN = l; enP = p; enT = t; preset = pv;
    if (!c)           mdl = '0;
    else if (!l)      mdl = pv;
    else if (p && t)  mdl = mdl + 8'd1;
    it.cnt  = mdl;
    it.cy   = t && (mdl == 8'hFF);
    it.cnt1 = mdl[3:0];
    it.cy1  = t && (mdl[3:0] == 4'hF);
    it.tag  = tag;
    sb.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      check(count == e.cnt,    {e.tag, " count"},  count,    e.cnt);
      check(carryOut == e.cy,  {e.tag, " carry"},  carryOut, e.cy);
      check(count1 == e.cnt1,  {e.tag, " count1"}, count1,   e.cnt1);
      check(carry1 == e.cy1,   {e.tag, " carry1"}, carry1,   e.cy1);
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: clear at an edge gives zero (reset state)
    step(0, 1, 0, 0, 8'h00, "R1 clear");
    // R3/R8: preset 12 = 4'b1100, bit 0 LSB
    step(1, 0, 1, 1, 8'h0C, "R3 R8 load12");
    step(1, 1, 1, 1, 8'h00, "R5 count13");
    step(1, 1, 1, 1, 8'h00, "R5 count14");
    step(1, 1, 1, 1, 8'h00, "R6 count15 nibble carry");
    step(1, 1, 1, 1, 8'h00, "R7 R9 nibble wrap");
    step(1, 1, 1, 1, 8'h00, "R5 count1");
    step(1, 1, 1, 1, 8'h00, "R5 count2");
    // R5: inhibit via each enable
    step(1, 1, 0, 1, 8'h00, "R5 hold enP low");
    step(1, 1, 1, 0, 8'h00, "R5 hold enT low");
    step(1, 1, 0, 0, 8'h00, "R5 hold both low");
    // R8: single LSB load
    step(1, 0, 0, 0, 8'h01, "R8 lsb load");
    step(1, 0, 0, 0, 8'h80, "R8 msb load");
    // R6: carry with enP low, all ones
    step(1, 0, 0, 1, 8'hFF, "R6 carry enP low");
    step(1, 1, 0, 1, 8'h00, "R6 carry holds");
    // R6: carry follows enT without an edge
    @(negedge clk);
    enT = 1'b0;
    #2;
    check(carryOut == 1'b0, "R6 carry drops with enT", carryOut, 0);
    check(carry1 == 1'b0,   "R6 nibble carry drops",   carry1,   0);
    enT = 1'b1;
    #2;
    check(carryOut == 1'b1, "R6 carry rises with enT", carryOut, 1);
    // R7: full-chain wrap
    step(1, 1, 1, 1, 8'h00, "R7 chain wrap");
    // R3: load beats counting
    step(1, 0, 1, 1, 8'h5A, "R3 load over count");
    // R4: clear beats load
    step(0, 0, 1, 1, 8'hA5, "R4 clear over load");
    // R9: full range from zero, 256 steps
    step(1, 0, 0, 0, 8'h00, "R9 load zero");
    for (int k = 0; k < 256; k++) step(1, 1, 1, 1, 8'h00, "R9 full range");
    // R2/R1: async clear mid-cycle versus synchronous clear
    step(1, 0, 0, 0, 8'h37, "R2 setup");
    @(negedge clk);
    clrN = 1'b0; loadN = 1'b1;
    #2;
    check(count1 == 4'h0, "R2 async clear before edge", count1, 0);
    check(count == 8'h37, "R1 sync clear waits edge",   count,  8'h37);
    step(0, 1, 0, 0, 8'h00, "R1 R2 clear edge");
    step(1, 1, 1, 1, 8'h00, "R5 count after clear");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule